// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Extended Memory-Reference Set

This block is a small accumulator processor driven by a timing-state counter. Each instruction is fetched from a 4K-word, 32-bit memory, decoded, given its effective address or addresses, and executed over a fixed run of timing states. No instruction uses a state beyond T6. The memory-reference set has three groups. The immediate group combines the accumulator with a 16-bit field from the instruction word. The one-operand group combines the accumulator with a memory word fed straight into the ALU. The two-operand group first parks one memory word in the data register and then combines it with a second memory word.

While reset is held, a write port fills memory, and a read port lets the surrounding logic inspect any word. After reset is released the processor starts fetching at address 0. It runs until it decodes the halt opcode and then holds every register. The asynchronous reset is released synchronously, two clock edges after the input goes high.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, the accumulator, program counter and `halted` read 0, and each cycle with `ld_en` high writes `ld_data` to word `ld_addr`. Two rising edges after `rst_n` goes high, the fetch of the word at address 0 begins.
- R2: Instruction word fields: bit 31 is the indirect flag and bits 30:26 hold the opcode. Bits 23:12 hold the first address, bits 11:0 the only or second address, and bits 15:0 the immediate (zero-extended). Opcodes: AND 0, OR 1, XOR 2, ADD 3, SUB 4, LDA 5, STA 6, BUN 7, ANDI 8, ORI 9, XORI 10, ADDI 11, SUBI 12, LDI 13, BSA 14, ISZ 15, ANDD 16, ORD 17, XORD 18, ADDD 19, SUBD 20, STI 21, HLT 31. Any other opcode does nothing.
- R3: Immediate opcodes 8 to 13 set the accumulator to AC op imm (LDI loads imm) and take 3 cycles.
- R4: Opcodes 0 to 5 set the accumulator to AC op M[EA] (LDA loads M[EA]). EA comes from bits 11:0. The memory word reaches the ALU without being stored in the data register. These opcodes take 5 cycles.
- R5: Opcodes 16 to 20 set the accumulator to M[EA1] op M[EA2]. EA1 comes from bits 23:12 and EA2 from bits 11:0. These opcodes take 7 cycles.
- R6: STA writes the accumulator to M[EA], with EA from bits 11:0. STI writes the zero-extended bits 15:0 to M[EA], with EA from bits 23:12. Both take 5 cycles.
- R7: BUN sets the program counter to EA. BSA writes the return address (the address after the BSA) to M[EA] and sets the program counter to EA+1. Both take 5 cycles.
- R8: ISZ writes M[EA]+1 back to M[EA] and skips the next instruction when that value is zero. It takes 5 cycles.
- R9: With bit 31 set, every address field the instruction uses is replaced by bits 11:0 of the word it points to. For two-operand opcodes this applies to both fields.
- R10: Subtraction is AC − operand (M[EA1] − M[EA2] for SUBD) in 32-bit two's complement, wrapping modulo 2^32. Addition wraps the same way.
- R11: The timing counter never passes T6 and returns to T0 when each instruction completes.
- R12: Opcode 31 raises `halted`. From then on, the accumulator, program counter and memory stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Memory preload write enable, honoured during reset |
| ld_addr | input | 12 | Memory preload address |
| ld_data | input | 32 | Memory preload data |
| peek_addr | input | 12 | Memory inspection address |
| peek_data | output | 32 | Memory word at `peek_addr` (combinational) |
| halted | output | 1 | Processor has executed the halt opcode |
| acc | output | 32 | Accumulator |
| pc | output | 12 | Program counter |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 12-bit addresses covering all 4K words, a 16-bit immediate and a 5-bit opcode. These defaults put 32-bit wrap-around in subtraction and in ISZ reaching zero within reach. They also allow the full 4K image to be loaded and compared word by word. A second 12-bit address field fits beside the opcode, so the two-operand group can be exercised with both fields indirect.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    ALU_AND   = 3'b000,
    ALU_OR    = 3'b001,
    ALU_XOR   = 3'b010,
    ALU_ADD   = 3'b011,
    ALU_SUB   = 3'b100,
    ALU_PASSB = 3'b101,
    ALU_INC   = 3'b110
  } alu_sel_e;

  // Opcode low three bits double as the ALU select for the arithmetic groups.
  localparam logic [4:0] OP_AND  = 5'd0;
  localparam logic [4:0] OP_SUB  = 5'd4;
  localparam logic [4:0] OP_LDA  = 5'd5;
  localparam logic [4:0] OP_STA  = 5'd6;
  localparam logic [4:0] OP_BUN  = 5'd7;
  localparam logic [4:0] OP_ANDI = 5'd8;
  localparam logic [4:0] OP_LDI  = 5'd13;
  localparam logic [4:0] OP_BSA  = 5'd14;
  localparam logic [4:0] OP_ISZ  = 5'd15;
  localparam logic [4:0] OP_ANDD = 5'd16;
  localparam logic [4:0] OP_SUBD = 5'd20;
  localparam logic [4:0] OP_STI  = 5'd21;
  localparam logic [4:0] OP_HLT  = 5'd31;

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_sel_e       sel,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (sel)
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_PASSB: y = b;
      ALU_INC:   y = b + W'(1);
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] paddr,
  output logic [DW-1:0] pdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
  assign pdata = words[paddr];
endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq #(
  parameter int SC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            clr,
  output logic [SC_W-1:0] sc
);
  logic [SC_W-1:0] sc_d;

  always_comb begin
    if (clr)      sc_d = '0;
    else if (adv) sc_d = sc + SC_W'(1);
    else          sc_d = sc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc <= '0;
    else        sc <= sc_d;
  end
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 5,
  parameter int SC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic              halted,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);
  localparam int IND_BIT = DATA_W - 1;
  localparam int OP_LO   = IND_BIT - OP_W;
  localparam int A1_LO   = ADDR_W;
  localparam int SPARE_LO = A1_LO + ADDR_W;
  localparam int SPARE_W  = OP_LO - SPARE_LO;

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [ADDR_W-1:0] ar, ar_d;
  logic [DATA_W-1:0] ir, dr, acc_d, mem_rdata, alu_y, alu_b, cpu_wd, imm;
  logic [ADDR_W-1:0] pc_d;
  logic ar_en, pc_en, ir_en, dr_en, acc_en, halt_set, sc_clr, cpu_we, run;
  logic [SC_W-1:0] sc;

  // Field decode
  logic [OP_W-1:0]   op;
  logic              ind;
  logic [ADDR_W-1:0] fld1, fld2;
  logic grp_imm, grp_two, grp_single;
  assign op   = ir[OP_LO +: OP_W];
  assign ind  = ir[IND_BIT];
  assign fld1 = ir[A1_LO +: ADDR_W];
  assign fld2 = ir[ADDR_W-1:0];
  assign imm  = DATA_W'(ir[IMM_W-1:0]);
  assign grp_imm    = (op >= OP_ANDI) && (op <= OP_LDI);
  assign grp_two    = (op >= OP_ANDD) && (op <= OP_SUBD);
  assign grp_single = (op <= OP_BUN) || (op == OP_BSA) || (op == OP_ISZ) || (op == OP_STI);

  logic unused_spare;
  assign unused_spare = ^ir[SPARE_LO +: SPARE_W];

  // Memory operand feeds the ALU directly; DR only for the two-operand group.
  alu_sel_e alu_sel;
  assign alu_sel = (op == OP_ISZ) ? ALU_INC : alu_sel_e'(op[2:0]);
  assign alu_b   = grp_imm ? imm : mem_rdata;

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .sel (alu_sel),
    .a   (grp_two ? dr : acc),
    .b   (alu_b),
    .y   (alu_y)
  );

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  assign mem_we    = rst_q_n ? cpu_we : ld_en;
  assign mem_waddr = rst_q_n ? ar : ld_addr;
  assign mem_wdata = rst_q_n ? cpu_wd : ld_data;

  acc_cpu_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ar),
    .rdata (mem_rdata),
    .paddr (peek_addr),
    .pdata (peek_data)
  );

  assign run = rst_q_n && !halted;

  acc_cpu_seq #(.SC_W(SC_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .adv   (run),
    .clr   (run && sc_clr),
    .sc    (sc)
  );

  // Next-state and enables per timing state
  always_comb begin
    ar_en = 1'b0;  ar_d = ar;
    pc_en = 1'b0;  pc_d = pc;
    ir_en = 1'b0;  dr_en = 1'b0;
    acc_en = 1'b0; acc_d = alu_y;
    halt_set = 1'b0; sc_clr = 1'b0;
    cpu_we = 1'b0; cpu_wd = acc;
    if (run) begin
      case (sc)
        SC_W'(0): begin ar_en = 1'b1; ar_d = pc; end
        SC_W'(1): begin ir_en = 1'b1; pc_en = 1'b1; pc_d = pc + ADDR_W'(1); end
        SC_W'(2): begin
          if (op == OP_HLT) halt_set = 1'b1;
          else if (grp_imm) begin acc_en = 1'b1; sc_clr = 1'b1; end
          else if (grp_two || grp_single) begin
            ar_en = 1'b1;
            ar_d  = (grp_two || op == OP_STI) ? fld1 : fld2;
          end
          else sc_clr = 1'b1;
        end
        SC_W'(3): if (ind) begin ar_en = 1'b1; ar_d = mem_rdata[ADDR_W-1:0]; end
        SC_W'(4): begin
          if (grp_two) begin
            dr_en = 1'b1; ar_en = 1'b1; ar_d = fld2;
          end else begin
            sc_clr = 1'b1;
            if (op <= OP_LDA) acc_en = 1'b1;
            else case (op)
              OP_STA: cpu_we = 1'b1;
              OP_STI: begin cpu_we = 1'b1; cpu_wd = imm; end
              OP_BUN: begin pc_en = 1'b1; pc_d = ar; end
              OP_BSA: begin
                cpu_we = 1'b1; cpu_wd = DATA_W'(pc);
                pc_en = 1'b1;  pc_d = ar + ADDR_W'(1);
              end
              OP_ISZ: begin
                cpu_we = 1'b1; cpu_wd = alu_y;
                if (alu_y == '0) begin pc_en = 1'b1; pc_d = pc + ADDR_W'(1); end
              end
              default: ;
            endcase
          end
        end
        SC_W'(5): if (ind) begin ar_en = 1'b1; ar_d = mem_rdata[ADDR_W-1:0]; end
        SC_W'(6): begin acc_en = 1'b1; sc_clr = 1'b1; end
        default:  sc_clr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ar <= '0; pc <= '0; ir <= '0; dr <= '0; acc <= '0; halted <= 1'b0;
    end else begin
      if (ar_en)    ar     <= ar_d;
      if (pc_en)    pc     <= pc_d;
      if (ir_en)    ir     <= mem_rdata;
      if (dr_en)    dr     <= mem_rdata;
      if (acc_en)   acc    <= acc_d;
      if (halt_set) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 5,
  parameter int SC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SC_W-1:0]   sc,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc,
  input logic              halted
);
  logic [OP_W-1:0] op;
  assign op = ir[DATA_W-1-OP_W +: OP_W];
  logic unused_chk;
  assign unused_chk = ^ir;

  // R11: never beyond T6
  p_sc_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= SC_W'(6));

  // R11: fetch state advances the program counter by one
  p_fetch_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == SC_W'(1) && !halted) |=> (pc == $past(pc) + ADDR_W'(1)));

  // R12: halt freezes architectural state
  p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  // R4: one-operand execution leaves the data register untouched
  p_dr_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == SC_W'(4) && op <= OP_W'(5) && !halted) |=> $stable(dr));

  // R3: immediate instructions complete at T2
  p_imm_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == SC_W'(2) && op >= OP_W'(8) && op <= OP_W'(13) && !halted) |=> (sc == '0));

  // R5: two-operand instructions run through T6
  p_two_op_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == SC_W'(5) && op >= OP_W'(16) && op <= OP_W'(20)) |=> (sc == SC_W'(6)));
endmodule

bind acc_cpu acc_cpu_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .OP_W   (OP_W),
  .SC_W   (SC_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .sc     (sc),
  .ir     (ir),
  .dr     (dr),
  .acc    (acc),
  .pc     (pc),
  .halted (halted)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  localparam int DEPTH = 4096;
  localparam logic [4:0] O_AND=0, O_OR=1, O_XOR=2, O_ADD=3, O_SUB=4, O_LDA=5, O_STA=6, O_BUN=7,
    O_ANDI=8, O_ORI=9, O_XORI=10, O_ADDI=11, O_SUBI=12, O_LDI=13, O_BSA=14, O_ISZ=15,
    O_ANDD=16, O_ORD=17, O_XORD=18, O_ADDD=19, O_SUBD=20, O_STI=21, O_HLT=31;

  logic clk = 1'b0;
  logic rst_n, ld_en, halted;
  logic [11:0] ld_addr, peek_addr, pc;
  logic [31:0] ld_data, peek_data, acc;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data), .halted(halted), .acc(acc), .pc(pc)
  );

  initial forever #4 clk = ~clk;

  int checks = 0, errors = 0;
  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];
  logic [31:0] img [DEPTH];
  logic [31:0] mm  [DEPTH];
  bit mon_en = 1'b0;
  logic [31:0] mon_prev;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input bit ind, input logic [4:0] op,
                                      input logic [11:0] a1, input logic [11:0] a2);
    return {ind, op, 2'b00, a1, a2};
  endfunction

  function automatic logic [31:0] iw(input logic [4:0] op, input logic [15:0] v);
    return {1'b0, op, 10'b0, v};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    case (s)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return a + b;
      3'd4: return a - b;
      default: return b;
    endcase
  endfunction

  function automatic logic [11:0] eff(input bit ind, input logic [11:0] f);
    return ind ? mm[f][11:0] : f;
  endfunction

  // Driver side: instruction-level model pushes expected accumulator results.
  task automatic model_run(output int cyc, output logic [11:0] pc_end);
    logic [31:0] a_m, ir, nacc;
    logic [11:0] p, ea, e1, e2;
    logic [4:0] op;
    bit ind;
    string tag;
    for (int i = 0; i < DEPTH; i++) mm[i] = img[i];
    a_m = '0; p = '0; cyc = 2;
    for (int step = 0; step < 2000; step++) begin
      ir = mm[p]; p = p + 12'd1;
      op = ir[30:26]; ind = ir[31]; nacc = a_m;
      if (op == O_HLT) begin cyc += 3; break; end
      if (op >= O_ANDI && op <= O_LDI) begin
        cyc += 3; tag = (op == O_SUBI) ? "R10" : "R3";
        nacc = ref_alu(op[2:0], a_m, {16'b0, ir[15:0]});
      end else if (op >= O_ANDD && op <= O_SUBD) begin
        cyc += 7; tag = ind ? "R9" : ((op == O_SUBD) ? "R10" : "R5");
        e1 = eff(ind, ir[23:12]); e2 = eff(ind, ir[11:0]);
        nacc = ref_alu(op[2:0], mm[e1], mm[e2]);
      end else if (op <= O_BUN || op == O_BSA || op == O_ISZ || op == O_STI) begin
        cyc += 5; tag = ind ? "R9" : ((op == O_SUB) ? "R10" : "R4");
        ea = eff(ind, (op == O_STI) ? ir[23:12] : ir[11:0]);
        if (op <= O_LDA) nacc = ref_alu(op[2:0], a_m, mm[ea]);
        else if (op == O_STA) mm[ea] = a_m;
        else if (op == O_STI) mm[ea] = {16'b0, ir[15:0]};
        else if (op == O_BUN) p = ea;
        else if (op == O_BSA) begin mm[ea] = {20'b0, p}; p = ea + 12'd1; end
        else begin
          mm[ea] = mm[ea] + 32'd1;
          if (mm[ea] == 32'd0) p = p + 12'd1;
        end
      end else cyc += 3;
      if (nacc !== a_m) begin sb.push_back('{nacc, tag}); a_m = nacc; end
    end
    pc_end = p;
  endtask

  // Monitor side: every accumulator change is popped and compared.
  initial begin
    forever begin : mon_body
      exp_t e;
      @(posedge clk); #1;
      if (mon_en && acc !== mon_prev) begin
        if (sb.size() == 0) chk(1'b0, "R12", "unexpected accumulator update", acc, mon_prev);
        else begin
          e = sb.pop_front();
          chk(acc === e.val, e.tag, "accumulator result", acc, e.val);
        end
        mon_prev = acc;
      end
    end
  end

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    peek_addr = a; #1; d = peek_data;
  endtask

  task automatic run_prog();
    int exp_cyc, n, mism;
    logic [11:0] exp_pc, hold_pc;
    logic [31:0] hold_acc, d;
    mon_en = 1'b0; rst_n = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    chk(acc === 32'd0, "R1", "accumulator in reset", acc, 32'd0);
    chk(pc === 12'd0 && halted === 1'b0, "R1", "pc/halted in reset", {19'b0, halted, pc}, 32'd0);
    for (int a = 0; a < DEPTH; a++) begin
      ld_en = 1'b1; ld_addr = 12'(a); ld_data = img[a];
      @(negedge clk);
    end
    ld_en = 1'b0;
    sb.delete();
    model_run(exp_cyc, exp_pc);
    mon_prev = acc; mon_en = 1'b1;
    rst_n = 1'b1; n = 0;
    while (halted !== 1'b1 && n < 5000) begin @(posedge clk); #1; n++; end
    if (halted !== 1'b1) chk(1'b0, "R12", "halt never reached", 32'(n), 32'(exp_cyc));
    else chk(n == exp_cyc, "R11", "cycles from reset release to halt", 32'(n), 32'(exp_cyc));
    chk(pc === exp_pc, "R7", "final program counter", {20'b0, pc}, {20'b0, exp_pc});
    hold_acc = acc; hold_pc = pc;
    repeat (20) @(posedge clk);
    #1;
    chk(acc === hold_acc && pc === hold_pc && halted === 1'b1, "R12", "state held after halt", acc, hold_acc);
    chk(sb.size() == 0, "R5", "expected results never produced", 32'(sb.size()), 32'd0);
    mism = 0;
    for (int a = 0; a < DEPTH; a++) begin
      peek(12'(a), d);
      if (d !== mm[a]) mism++;
    end
    chk(mism == 0, "R6", "memory words differing from model", 32'(mism), 32'd0);
    mon_en = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL R11 watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0; peek_addr = '0;
    // Program A: every group, wrap, indirect, store, branch, skip
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
    img[0]  = iw(O_LDI, 16'h1234);
    img[1]  = iw(O_ADDI, 16'h0010);
    img[2]  = iw(O_ANDI, 16'h00FF);
    img[3]  = iw(O_ORI, 16'hF000);
    img[4]  = iw(O_XORI, 16'h0044);
    img[5]  = iw(O_SUBI, 16'hF001);
    img[6]  = ins(0, O_LDA, 0, 12'h100);
    img[7]  = ins(0, O_ADD, 0, 12'h101);
    img[8]  = ins(0, O_SUB, 0, 12'h102);
    img[9]  = ins(0, O_AND, 0, 12'h103);
    img[10] = ins(0, O_OR, 0, 12'h104);
    img[11] = ins(0, O_XOR, 0, 12'h105);
    img[12] = ins(1, O_ADD, 0, 12'h106);
    img[13] = ins(0, O_STA, 0, 12'h200);
    img[14] = ins(0, O_ADDD, 12'h100, 12'h101);
    img[15] = ins(0, O_SUBD, 12'h100, 12'h102);
    img[16] = ins(0, O_ANDD, 12'h103, 12'h104);
    img[17] = ins(0, O_ORD, 12'h103, 12'h104);
    img[18] = ins(1, O_XORD, 12'h106, 12'h107);
    img[19] = ins(0, O_STI, 12'h201, 12'hABC);
    img[20] = ins(0, O_ISZ, 0, 12'h108);
    img[21] = iw(O_LDI, 16'hDEAD);
    img[22] = ins(0, O_ISZ, 0, 12'h109);
    img[23] = ins(0, O_BUN, 0, 12'h030);
    img[12'h030] = ins(0, O_BSA, 0, 12'h040);
    img[12'h041] = iw(O_LDI, 16'h7777);
    img[12'h042] = ins(1, O_BUN, 0, 12'h10A);
    img[12'h050] = ins(1, O_LDA, 0, 12'h10B);
    img[12'h051] = iw(O_ADDI, 16'h0001);
    img[12'h052] = ins(0, O_HLT, 0, 0);
    img[12'h100] = 32'h0000_0005; img[12'h101] = 32'h0000_0010;
    img[12'h102] = 32'h0000_0020; img[12'h103] = 32'h0F0F_0F0F;
    img[12'h104] = 32'hF000_0000; img[12'h105] = 32'hFF00_0000;
    img[12'h106] = 32'h0000_0101; img[12'h107] = 32'h0000_0102;
    img[12'h108] = 32'hFFFF_FFFF; img[12'h109] = 32'h0000_0005;
    img[12'h10A] = 32'h0000_0050; img[12'h10B] = 32'h0000_0200;
    run_prog();
    chk(acc === 32'h000F_0F16, "R9", "final accumulator program A", acc, 32'h000F_0F16);
    peek(12'h200, d); chk(d === 32'h000F_0F15, "R6", "STA word", d, 32'h000F_0F15);
    peek(12'h201, d); chk(d === 32'h0000_1ABC, "R6", "STI word", d, 32'h0000_1ABC);
    peek(12'h040, d); chk(d === 32'h0000_0031, "R7", "BSA return address", d, 32'h0000_0031);
    peek(12'h108, d); chk(d === 32'h0000_0000, "R8", "ISZ wrap to zero", d, 32'h0);
    peek(12'h109, d); chk(d === 32'h0000_0006, "R8", "ISZ no skip", d, 32'h6);

    // Program B: fresh reset, wrap below zero, self two-operand, indirect ISZ
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
    img[0] = iw(O_SUBI, 16'h0001);
    img[1] = ins(0, O_XORD, 12'h100, 12'h100);
    img[2] = ins(1, O_ISZ, 0, 12'h10C);
    img[3] = iw(5'd25, 16'h0000);
    img[4] = ins(0, O_HLT, 0, 0);
    img[12'h100] = 32'hA5A5_5A5A;
    img[12'h10C] = 32'h0000_010D; img[12'h10D] = 32'h0000_0007;
    run_prog();
    chk(acc === 32'h0, "R5", "final accumulator program B", acc, 32'h0);
    chk(pc === 12'h005, "R2", "undefined opcode falls through", {20'b0, pc}, 32'h5);
    peek(12'h10D, d); chk(d === 32'h8, "R9", "indirect ISZ target", d, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule